// File: doc/BRIEF.md
# Output-Enable Configuration Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C protocol). It keeps one 8-bit register in which each bit switches one output channel off (1) or on (0). A controller writes the register with a single data byte and reads it back the same way. The bus has no register pointer, because there is only one register. SCL and SDA are brought into a fast system clock through two-flop synchronisers and turned into edge and bus-condition events. The target drives SDA only through an open-drain pull-down enable.

The 7-bit target address is a fixed five-bit prefix followed by two bits taken from strap pins. Several copies can therefore share one bus. A received byte first goes to a shadow byte. It reaches the live register only when a STOP closes a write whose data byte was acknowledged. The system clock must run at least 16 times faster than SCL.

Top module: `oecfg_target`

## Requirements
- R1: After reset, `chan_off_o` is 0xFF: bit n belongs to channel n, and 1 means the channel is off. `sda_oe_o` is low, so SDA is released.
- R2: The first byte after START is the address, MSB first: 1,1,0,1,0,`strap_i[1]`,`strap_i[0]`, then R/W (0 write, 1 read). When the address matches, the target pulls SDA low through the ninth SCL pulse.
- R3: When the address does not match, the target gives no acknowledge and keeps SDA released until the next START. The register keeps its value.
- R4: In a write, the data byte is shifted in MSB first and acknowledged by the target. `chan_off_o` takes the new value at the STOP that follows, and not before.
- R5: A write stopped by STOP before the ninth clock of its data byte leaves the register unchanged.
- R6: In a read, the target sends the live register MSB first, pulling SDA low only for 0 bits. It releases SDA for the controller's acknowledge bit.
- R7: A repeated START begins a new address phase. It discards a write that was acknowledged but not yet closed by STOP.
- R8: Bytes after the first data byte of a write are not acknowledged and have no effect on the register.
- R9: `sda_oe_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two bits of the target address |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan_off_o | output | 8 | Live register; bit n = 1 turns channel n off |

## Verification
The assertions assume the controller obeys the bus rules. SDA moves only while SCL is low, except at START and STOP. The two lines never toggle in the same system-clock cycle, and the strap pins are steady during a transaction. The bench keeps each SCL quarter period at ten system clocks and changes SDA mid-way through the low phase. It changes the straps only while the bus is idle, and it models the wired-AND line from its own drive and the target's pull-down. Under those conditions, every SDA change by the target lands after a synchronised SCL fall, and every register change lands on a detected STOP.

// File: rtl/oecfg_pkg.sv
package oecfg_pkg;
  localparam int BYTE_W   = 8;
  localparam int PREFIX_W = 5;
  localparam int STRAP_W  = 2;
  localparam int ADDR_W   = PREFIX_W + STRAP_W;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/oecfg_sync.sv
module oecfg_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], din[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign dout[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/oecfg_events.sv
module oecfg_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end
endmodule

// File: rtl/oecfg_fsm.sv
module oecfg_fsm
  import oecfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  live_val,
  output logic               sda_drv,
  output logic               shadow_we,
  output logic [BYTE_W-1:0]  shadow_d,
  output logic               arm
);
  tgt_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rw_q, rw_n;
  logic              drv_q, drv_n;
  logic              byte_done;
  logic [ADDR_W-1:0] my_addr;

  assign my_addr   = {ADDR_PREFIX, strap};
  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    rw_n      = rw_q;
    drv_n     = drv_q;
    shadow_we = 1'b0;
    arm       = 1'b0;
    if (start_evt) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      drv_n   = 1'b0;
    end else if (stop_evt) begin
      state_n = ST_IDLE;
      drv_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_done) begin
            if (sh_q[BYTE_W-1:1] == my_addr) begin
              state_n = ST_ADDR_ACK;
              drv_n   = 1'b1;
              rw_n    = sh_q[0];
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              state_n = ST_RD_BYTE;
              sh_n    = live_val;
              drv_n   = ~live_val[BYTE_W-1];
            end else begin
              state_n = ST_WR_BYTE;
              drv_n   = 1'b0;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_done) begin
            state_n   = ST_WR_ACK;
            drv_n     = 1'b1;
            shadow_we = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_n = ST_SKIP;
            drv_n   = 1'b0;
            arm     = 1'b1;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (byte_done) begin
              state_n = ST_RD_ACK;
              drv_n   = 1'b0;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              drv_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) state_n = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rw_q    <= rw_n;
      drv_q   <= drv_n;
    end
  end

  assign sda_drv  = drv_q;
  assign shadow_d = sh_q;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_q) |-> !$past(scl_s)); // R9
  AST_ACK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> drv_q); // R2
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !drv_q); // R3
  AST_RD_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK) |-> !drv_q); // R6
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR)); // R7
endmodule

// File: rtl/oecfg_regs.sv
module oecfg_regs
  import oecfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shadow_we,
  input  logic [BYTE_W-1:0] shadow_d,
  input  logic              arm,
  input  logic              drop,
  input  logic              commit,
  output logic [BYTE_W-1:0] live
);
  logic [BYTE_W-1:0] shadow_q, shadow_n;
  logic [BYTE_W-1:0] live_q, live_n;
  logic              pend_q, pend_n;

  always_comb begin
    shadow_n = shadow_we ? shadow_d : shadow_q;
    live_n   = (commit && pend_q) ? shadow_q : live_q;
    if (drop || commit) pend_n = 1'b0;
    else if (arm)       pend_n = 1'b1;
    else                pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '1;
      live_q   <= '1;
      pend_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_n;
      live_q   <= live_n;
      pend_q   <= pend_n;
    end
  end

  assign live = live_q;

  AST_LIVE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_q) |-> $past(commit)); // R4
  AST_NO_PEND_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !pend_q); // R7
endmodule

// File: rtl/oecfg_target.sv
module oecfg_target
  import oecfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  chan_off_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [1:0]        lines_s;
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              shadow_we, arm;
  logic [BYTE_W-1:0] shadow_d, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  oecfg_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din({scl_i, sda_i}), .dout(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  oecfg_events u_events (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  oecfg_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(strap_i), .live_val(live), .sda_drv(sda_oe_o),
    .shadow_we(shadow_we), .shadow_d(shadow_d), .arm(arm)
  );

  oecfg_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .shadow_we(shadow_we), .shadow_d(shadow_d),
    .arm(arm), .drop(start_evt), .commit(stop_evt), .live(live)
  );

  assign chan_off_o = live;
endmodule

// File: tb/oecfg_target_bench.sv
module oecfg_target_bench;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_c = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       sda_oe;
  logic [7:0] chan_off;
  logic       sda_line;
  int checks = 0;
  int errors = 0;
  int r9_viol = 0;
  logic [7:0] exp_reg;
  logic       prev_oe = 1'b0;

  assign sda_line = sda_c & ~sda_oe;

  oecfg_target u_oecfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .chan_off_o(chan_off)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== prev_oe)) r9_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; waitq();
    scl = 1'b1;   waitq();
    sda_c = 1'b0; waitq();
    scl = 1'b0;   waitq();
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; waitq();
    scl = 1'b1;   waitq();
    sda_c = 1'b1; waitq();
    waitq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_c = b; waitq();
    scl = 1'b1; waitq();
    seen = sda_line; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d, output logic ack_line);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(nack, ack_line);
  endtask

  localparam logic [4:0] PFX = 5'b11010;

  initial begin
    logic       ack, s;
    logic [6:0] addr;
    logic [7:0] d, rd;
    bit         match;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(chan_off == 8'hFF, "R1 reset register", chan_off, 8'hFF);
    chk(sda_oe == 1'b0, "R1 reset sda released", {7'd0, sda_oe}, 8'h00);
    exp_reg = 8'hFF;

    // R2 R3 R4 address sweep over all straps
    for (int st = 0; st < 4; st++) begin
      strap = st[1:0];
      for (int c = 0; c < 9; c++) begin
        if (c < 4) addr = {PFX, c[1:0]};
        else       addr = {PFX ^ (5'b00001 << (c - 4)), st[1:0]};
        match = (addr == {PFX, st[1:0]});
        d = 8'h3C ^ 8'((c * 17) + (st * 5));
        bus_start();
        send_byte({addr, 1'b0}, ack);
        chk(ack == match, match ? "R2 address ack" : "R3 mismatch no ack",
            {7'd0, ack}, {7'd0, match});
        send_byte(d, ack);
        if (match) chk(ack == 1'b1, "R4 data ack", {7'd0, ack}, 8'h01);
        else       chk(ack == 1'b0, "R3 released after mismatch", {7'd0, ack}, 8'h00);
        chk(chan_off == exp_reg, "R4 unchanged before stop", chan_off, exp_reg);
        bus_stop();
        if (match) exp_reg = d;
        chk(chan_off == exp_reg, "R4 value after stop", chan_off, exp_reg);
      end
    end

    // R6 readback sweep with walking patterns
    strap = 2'b10;
    for (int i = 0; i < 16; i++) begin
      d = (i < 8) ? (8'h01 << i) : ~(8'h01 << (i - 8));
      bus_start();
      send_byte({PFX, 2'b10, 1'b0}, ack);
      send_byte(d, ack);
      bus_stop();
      exp_reg = d;
      bus_start();
      send_byte({PFX, 2'b10, 1'b1}, ack);
      chk(ack == 1'b1, "R2 read address ack", {7'd0, ack}, 8'h01);
      recv_byte(1'b1, rd, s);
      chk(rd == exp_reg, "R6 read data", rd, exp_reg);
      chk(s == 1'b1, "R6 released at controller ack", {7'd0, s}, 8'h01);
      bus_stop();
    end

    // R5 write cut short by STOP
    bus_start();
    send_byte({PFX, 2'b10, 1'b0}, ack);
    for (int i = 0; i < 5; i++) clk_bit(1'b0, s);
    bus_stop();
    chk(chan_off == exp_reg, "R5 aborted write", chan_off, exp_reg);

    // R8 extra byte not acknowledged, no effect
    bus_start();
    send_byte({PFX, 2'b10, 1'b0}, ack);
    send_byte(8'h5A, ack);
    send_byte(8'hC3, ack);
    chk(ack == 1'b0, "R8 extra byte nack", {7'd0, ack}, 8'h00);
    bus_stop();
    exp_reg = 8'h5A;
    chk(chan_off == exp_reg, "R8 first byte kept", chan_off, exp_reg);

    // R7 repeated start discards pending write, then read old value
    bus_start();
    send_byte({PFX, 2'b10, 1'b0}, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte({PFX, 2'b10, 1'b1}, ack);
    chk(ack == 1'b1, "R7 address after repeated start", {7'd0, ack}, 8'h01);
    recv_byte(1'b1, rd, s);
    chk(rd == exp_reg, "R7 read after repeated start", rd, exp_reg);
    bus_stop();
    chk(chan_off == exp_reg, "R7 pending write dropped", chan_off, exp_reg);

    // R7 write, repeated start, second write commits at stop
    bus_start();
    send_byte({PFX, 2'b10, 1'b0}, ack);
    send_byte(8'h22, ack);
    bus_start();
    send_byte({PFX, 2'b10, 1'b0}, ack);
    send_byte(8'h96, ack);
    bus_stop();
    exp_reg = 8'h96;
    chk(chan_off == exp_reg, "R7 second write after repeated start", chan_off, exp_reg);

    // R9 target never moved SDA while SCL high
    chk(r9_viol == 0, "R9 sda change while scl high", 8'(r9_viol), 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule